// File: doc/BRIEF.md
# Receive Buffer with Per-Character Error Tags and Line Status

This block sits behind the bit-level receiver of a 16550-style serial controller. Each time the receiver finishes a character it presents the byte on `rx_data` for one cycle with `rx_valid`. Alongside the byte come three error flags: parity error, framing error and break. The block stores the byte together with its own flags. With `fifo_en` high the store is a first-in first-out buffer of `DEPTH` entries. With `fifo_en` low it is a single holding stage. A CPU-side register interface reads the oldest byte with a one-cycle `rd_data` strobe, and clears the sticky status with a one-cycle `rd_status` strobe.

The status byte is always visible on `status`. Some of its bits are live and some are sticky. The error bits of a character are shown only while that character is the oldest one in the buffer. An overrun is reported independently of any stored entry. A summary bit remembers that an errored character was held somewhere in the buffer. The two transmit bits are formed from `tx_hold_empty` and `tx_shift_empty`, which come from the transmit side. `lsr_irq` is the receiver line status interrupt. `DEPTH` must be a power of two.

Top module: `rx_line_status`

## Requirements
- R1: `status[0]` is 1 whenever at least one character is buffered, and it returns to 0 only after the last buffered character has been read with `rd_data`.
- R2: In FIFO mode up to `DEPTH` (16) characters are held. `data_out` shows the oldest one, and each `rd_data` pulse removes it, so bytes leave in arrival order. `data_out` reads 0 when the buffer is empty.
- R3: In FIFO mode, a character that completes while the buffer is full and no read happens in that cycle sets `status[1]`. That character is discarded and the stored contents are unchanged.
- R4: `status[1]` clears on a `rd_status` pulse, unless an overrun occurs in the same cycle, in which case it stays 1.
- R5: `status[2]` (parity), `status[3]` (framing) and `status[4]` (break) show the flags stored with the oldest character. A `rd_status` pulse masks them to 0 until a different character becomes the oldest.
- R6: `lsr_irq` is 1 exactly when any of `status[4:1]` is 1.
- R7: `status[5]` equals `tx_hold_empty`, and `status[6]` is 1 only when both `tx_hold_empty` and `tx_shift_empty` are 1.
- R8: In FIFO mode `status[7]` is 1 while any stored character carries a flag. After the last errored character leaves, it stays 1 until a `rd_status` pulse, which clears it only if no errored character remains.
- R9: In non-FIFO mode the buffer holds one character. A new character arriving while it is unread replaces it and sets `status[1]`. `status[7]` is 0 in this mode.
- R10: A change of `fifo_en` empties the buffer on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 selects FIFO mode, 0 selects the single holding stage |
| rx_valid | input | 1 | One-cycle strobe: a received character is complete |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error flag of the received byte |
| rx_ferr | input | 1 | Framing error flag of the received byte |
| rx_brk | input | 1 | Break flag of the received byte |
| rd_data | input | 1 | One-cycle strobe: CPU reads the oldest byte |
| rd_status | input | 1 | One-cycle strobe: CPU reads the status byte |
| tx_hold_empty | input | 1 | Transmit holding stage or transmit FIFO is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| data_out | output | 8 | Oldest buffered byte |
| status | output | 8 | Line status byte |
| lsr_irq | output | 1 | Receiver line status interrupt |

## Verification
A wrong read or write pointer shows up on `data_out` at the very next pop, as a byte out of arrival order. A wrong tag shows up on `status[4:2]` in the same cycle that the affected character reaches the head. A wrong entry count shows up at the sixteenth or seventeenth arrival: `status[1]` rises too early or too late, or `status[0]` drops before the last byte is read. Stale sticky state, in the overrun bit, the head mask or the summary bit, is visible one cycle after the `rd_status` pulse that should have changed it.

// File: rtl/rx_line_status.sv
module rx_line_status #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          rx_brk,
  input  logic          rd_data,
  input  logic          rd_status,
  input  logic          tx_hold_empty,
  input  logic          tx_shift_empty,
  output logic [DW-1:0] data_out,
  output logic [7:0]    status,
  output logic          lsr_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = DW + 3;
  localparam int CW = AW + 1;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, errcnt, errcnt_nx;
  logic          mode_q, oe_q, ack_q, sum_q;

  wire           flush    = fifo_en != mode_q;
  wire           empty    = cnt == '0;
  wire           full     = fifo_en ? (cnt == CW'(DEPTH)) : !empty;
  wire           pop      = rd_data && !empty && !flush;
  wire           push     = rx_valid && !flush && (!full || pop);
  wire           ovr      = rx_valid && !flush && full && !pop;
  wire           ovw      = ovr && !fifo_en;
  wire           in_err   = rx_perr | rx_ferr | rx_brk;
  wire [EW-1:0]  in_word  = {rx_brk, rx_ferr, rx_perr, rx_data};
  wire [EW-1:0]  head     = mem[rp];
  wire [2:0]     head_fl  = head[EW-1:DW];
  wire           head_err = |head_fl;
  wire           head_chg = pop | (push && empty) | ovw | flush;

  always_comb begin
    if (flush)
      errcnt_nx = '0;
    else
      errcnt_nx = errcnt
                + CW'(push && in_err) + CW'(ovw && in_err)
                - CW'(pop && head_err) - CW'(ovw && head_err);
  end

  always_ff @(posedge clk) begin
    if (push)
      mem[wp] <= in_word;
    if (ovw)
      mem[rp] <= in_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      errcnt <= '0;
      mode_q <= 1'b0;
      oe_q   <= 1'b0;
      ack_q  <= 1'b0;
      sum_q  <= 1'b0;
    end else begin
      mode_q <= fifo_en;
      errcnt <= errcnt_nx;
      if (flush) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push) wp <= wp + 1'b1;
        if (pop)  rp <= rp + 1'b1;
        cnt <= cnt + CW'(push) - CW'(pop);
      end
      oe_q  <= ovr | (oe_q & ~rd_status);
      ack_q <= head_chg ? 1'b0 : (ack_q | rd_status);
      sum_q <= fifo_en && !flush && ((errcnt_nx != '0) || (sum_q && !rd_status));
    end
  end

  assign data_out = empty ? '0 : head[DW-1:0];
  assign status   = {sum_q,
                     tx_hold_empty & tx_shift_empty,
                     tx_hold_empty,
                     head_fl & {3{!empty && !ack_q}},
                     oe_q,
                     !empty};
  assign lsr_irq  = |status[4:1];
endmodule

module rx_line_status_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fifo_en,
  input logic                       rx_valid,
  input logic                       rd_data,
  input logic                       rd_status,
  input logic [DW-1:0]              data_out,
  input logic [7:0]                 status,
  input logic                       lsr_irq,
  input logic [$clog2(DEPTH):0]     cnt,
  input logic                       mode_q
);
  localparam int CW = $clog2(DEPTH) + 1;

  // R3
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && mode_q && cnt == CW'(DEPTH) && rx_valid && !rd_data |=> status[1]);

  // R3
  full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && mode_q && cnt == CW'(DEPTH) && rx_valid && !rd_data |=> $stable(data_out));

  // R4
  oe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && !rx_valid |=> !status[1]);

  // R6
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && !rx_valid && !rd_data && fifo_en == mode_q |=> !lsr_irq);

  // R7
  tx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |-> status[5]);

  // R9
  hold_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> cnt <= CW'(1));

  // R9
  nofifo_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en && !mode_q |-> !status[7]);

  // R1
  dr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && cnt == CW'(1) && !rx_valid && fifo_en == mode_q |=> !status[0]);
endmodule

bind rx_line_status rx_line_status_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_valid(rx_valid),
  .rd_data(rd_data), .rd_status(rd_status), .data_out(data_out),
  .status(status), .lsr_irq(lsr_irq), .cnt(cnt), .mode_q(mode_q));

// File: tb/tb_rx_line_status.sv
`timescale 1ns/1ps
module tb_rx_line_status;
  logic clk = 0, rst_n = 0, fifo_en = 1, rx_valid = 0, rd_data = 0, rd_status = 0;
  logic rx_perr = 0, rx_ferr = 0, rx_brk = 0, tx_hold_empty = 0, tx_shift_empty = 0;
  logic [7:0] rx_data = 0, data_out, status;
  logic lsr_irq;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  rx_line_status dut (.clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .rd_data(rd_data), .rd_status(rd_status), .tx_hold_empty(tx_hold_empty),
    .tx_shift_empty(tx_shift_empty), .data_out(data_out), .status(status), .lsr_irq(lsr_irq));

  function automatic logic [7:0] dval(int i); return 8'((i * 29 + 7) & 255); endfunction
  function automatic logic [2:0] fval(int i); return (i >= 8) ? 3'(i) : 3'b000; endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic [2:0] f, input logic rs);
    rx_data = d; {rx_brk, rx_ferr, rx_perr} = f; rx_valid = 1; rd_status = rs;
    @(negedge clk);
    rx_valid = 0; rd_status = 0; {rx_brk, rx_ferr, rx_perr} = 3'b000;
  endtask

  task automatic pulse(input logic rdd, input logic rds);
    rd_data = rdd; rd_status = rds;
    @(negedge clk);
    rd_data = 0; rd_status = 0;
  endtask

  initial begin
    #800000;
    failures++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset status", status, 8'h00);
    chk("R6 reset irq", {7'd0, lsr_irq}, 8'h00);
    // R7: sweep both transmit inputs
    for (int t = 0; t < 4; t++) begin
      {tx_shift_empty, tx_hold_empty} = 2'(t);
      #1;
      chk("R7 tx bits", {6'd0, status[6:5]}, {6'd0, (t == 3) ? 1'b1 : 1'b0, 1'(t & 1)});
    end
    tx_hold_empty = 1; tx_shift_empty = 1;

    for (int i = 0; i < 16; i++) send(dval(i), fval(i), 0);
    chk("R2/R8 full status", status, 8'hE1);
    chk("R2 head byte", data_out, dval(0));
    send(8'h5A, 3'b111, 0);
    chk("R3 overrun status", status, 8'hE3);
    chk("R6 overrun irq", {7'd0, lsr_irq}, 8'h01);
    chk("R3 discarded byte", data_out, dval(0));
    send(8'h77, 3'b000, 1);
    chk("R4 overrun kept on same-cycle read", status, 8'hE3);
    pulse(0, 1);
    chk("R4 overrun cleared", status, 8'hE1);
    chk("R6 irq cleared", {7'd0, lsr_irq}, 8'h00);

    for (int i = 0; i < 16; i++) begin
      chk("R2 order", data_out, dval(i));
      chk("R5 head flags", {5'd0, status[4:2]}, {5'd0, fval(i)});
      chk("R6 irq follows flags", {7'd0, lsr_irq}, {7'd0, |fval(i)});
      chk("R8 summary while stored", {7'd0, status[7]}, 8'h01);
      if (fval(i) != 0) begin
        pulse(0, 1);
        chk("R5 flags masked after read", {5'd0, status[4:2]}, 8'h00);
        chk("R8 summary kept", {7'd0, status[7]}, 8'h01);
      end
      chk("R1 ready before last", {7'd0, status[0]}, 8'h01);
      pulse(1, 0);
    end
    chk("R1/R8 drained sticky", status, 8'hE0);
    chk("R2 empty byte", data_out, 8'h00);
    pulse(0, 1);
    chk("R8 summary cleared", status, 8'h60);

    send(8'h11, 3'b001, 0);
    send(8'h22, 3'b000, 0);
    chk("R5/R8 parity head", status, 8'hE5);
    pulse(1, 0);
    chk("R8 sticky after errored left", status, 8'hE1);
    pulse(0, 1);
    chk("R8 cleared with clean remainder", status, 8'h61);
    pulse(1, 0);
    chk("R1 empty", status, 8'h60);

    send(8'h31, 3'b000, 0);
    send(8'h32, 3'b010, 0);
    send(8'h33, 3'b000, 0);
    chk("R10 before switch", status, 8'hE1);
    fifo_en = 0;
    @(negedge clk);
    chk("R10 flushed", status, 8'h60);
    chk("R10 flushed byte", data_out, 8'h00);
    send(8'hA5, 3'b001, 0);
    chk("R9 single char", status, 8'h65);
    chk("R9 single byte", data_out, 8'hA5);
    send(8'h3C, 3'b000, 0);
    chk("R9 overwrite status", status, 8'h63);
    chk("R9 overwrite byte", data_out, 8'h3C);
    send(8'hC3, 3'b100, 0);
    chk("R9 break no summary", status, 8'h73);
    pulse(1, 0);
    chk("R1/R9 read empties", status, 8'h62);
    pulse(0, 1);
    chk("R4 cleared non-fifo", status, 8'h60);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule